// File: doc/BRIEF.md
# Step/Direction Stepper Phase Translator

This block turns a step-pulse and direction command stream into the four logic signals that steer a two-phase bipolar stepper driver. Each phase gets a current-direction bit and a current-disable bit. One eight-position energizing cycle serves both half-step and full-step operation. In full-step operation only the even positions, where both phases carry current, are used. The direction and mode inputs are taken at the same moment the step is accepted, which is a falling edge of the step input.

Two more outputs are active low. The first marks the sequence-start position, so a host can combine it with a position sensor to find the motor's origin. The second goes low once no step has been accepted for a set number of clock cycles, so the driver can reduce its holding current. All inputs come from outside the clock domain and pass through two-flop synchronizers. The idle interval is counted in clock cycles, not set by an external RC network.

Top module: `stepper_phase_xlat`

## Requirements
- R1: The position advances only on a falling edge of `step_i`, and the outputs show the new position no later than 3 rising clock edges after that edge. A rising edge of `step_i` leaves every output unchanged.
- R2: The encoding of {phase_a_o, phase_b_o, dis_a_o, dis_b_o} by position is: 0=1100, 1=1101, 2=1000, 3=1010, 4=0000, 5=0001, 6=0100, 7=0110. At most one disable bit is high at any time.
- R3: When `full_step_i`=1, each accepted step starting from an even position moves 2 positions. The pattern then repeats every 4 steps and both disable bits stay low.
- R4: When `half_full` mode is low (`full_step_i`=0), each accepted step moves 1 position, and the pattern repeats every 8 steps.
- R5: `dir_i`=1 increases the position (modulo 8) and `dir_i`=0 decreases it.
- R6: In full-step mode, a step taken from an odd position moves exactly 1 position in the commanded direction, to an even position.
- R7: `dir_i` and `full_step_i` act only through their values at the falling edge of `step_i`. Changing them while no edge arrives leaves the outputs unchanged.
- R8: While `hold_ni` is low, the position is forced to 0 and falling edges of `step_i` are ignored.
- R9: After `rst_ni` is asserted, the position is 0 and the outputs show 1100 with `origin_no`=0.
- R10: `origin_no` is low exactly when the position is 0.
- R11: `idle_no` goes low once `IDLE_CYCLES` clock cycles pass with no accepted step. It returns high on the clock edge after an accepted step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| step_i | input | 1 | Step pulse; the falling edge advances the sequencer |
| dir_i | input | 1 | Direction: 1 forward, 0 reverse |
| full_step_i | input | 1 | Mode: 1 full-step, 0 half-step |
| hold_ni | input | 1 | Active-low sequence reset, synchronized |
| phase_a_o | output | 1 | Phase A current direction |
| phase_b_o | output | 1 | Phase B current direction |
| dis_a_o | output | 1 | Phase A current off |
| dis_b_o | output | 1 | Phase B current off |
| origin_no | output | 1 | Low at sequence start |
| idle_no | output | 1 | Low after the idle interval without a step |

## Verification
The hardest case to reach is R6. Full-step mode on an odd position occurs only when half-step pulses first leave the sequencer off the even grid and the mode is then switched before the next falling edge. The directed stimulus does this in both directions. The random stimulus switches the mode at every pulse, so odd-to-even realignment also occurs mixed with reversals. The idle output needs a long quiet stretch with no step, so the bench uses a short `IDLE_CYCLES` and waits just short of and just past that count.

// File: rtl/stepper_xlat_pkg.sv
package stepper_xlat_pkg;
  localparam int unsigned POS_W = 3;
  typedef logic [POS_W-1:0] pos_t;

  typedef struct packed {
    logic pa;
    logic pb;
    logic dis_a;
    logic dis_b;
  } drive_t;

  // pa high in first half-turn, pb high around position 0, disables on odd mid-points
  function automatic drive_t drive_of(pos_t p);
    drive_t d;
    d.pa    = ~p[2];
    d.pb    = (p[2] == p[1]);
    d.dis_a = p[0] & p[1];
    d.dis_b = p[0] & ~p[1];
    return d;
  endfunction
endpackage

// File: rtl/sync_bits.sv
module sync_bits #(
  parameter int unsigned       WIDTH   = 4,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[g];
        sync_q <= RST_VAL[g];
      end else begin
        meta_q <= d_i[g];
        sync_q <= meta_q;
      end
    end
    assign q_o[g] = sync_q;
  end
endmodule

// File: rtl/step_seq.sv
module step_seq
  import stepper_xlat_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_i,
  input  logic hold_ni,
  input  logic dir_i,
  input  logic full_i,
  output pos_t pos_o,
  output logic accept_o
);
  pos_t pos_q, pos_d, inc;

  assign accept_o = fall_i & hold_ni;

  always_comb begin
    // full-step from even: two positions; otherwise one (realigns odd to even)
    inc   = (full_i && !pos_q[0]) ? pos_t'(2) : pos_t'(1);
    pos_d = dir_i ? pos_q + inc : pos_q - inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pos_q <= '0;
    else if (!hold_ni)  pos_q <= '0;
    else if (accept_o)  pos_q <= pos_d;
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
  parameter int unsigned IDLE_CYCLES = 2_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic idle_o
);
  localparam int unsigned CNT_W = $clog2(IDLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clear_i)        cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign idle_o = (cnt_q == LIMIT);
endmodule

// File: rtl/stepper_phase_xlat.sv
module stepper_phase_xlat
  import stepper_xlat_pkg::*;
#(
  parameter int unsigned IDLE_CYCLES = 2_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic dir_i,
  input  logic full_step_i,
  input  logic hold_ni,
  output logic phase_a_o,
  output logic phase_b_o,
  output logic dis_a_o,
  output logic dis_b_o,
  output logic origin_no,
  output logic idle_no
);
  localparam int unsigned N_SYNC = 4;

  logic [N_SYNC-1:0] raw, synced;
  logic step_s, dir_s, full_s, hold_s;
  logic step_prev_q, fall, accept, idle;
  pos_t pos;
  drive_t drv;

  assign raw = {step_i, dir_i, full_step_i, hold_ni};
  assign {step_s, dir_s, full_s, hold_s} = synced;

  sync_bits #(.WIDTH(N_SYNC), .RST_VAL(4'b1111)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_prev_q <= 1'b1;
    else         step_prev_q <= step_s;
  end

  assign fall = step_prev_q & ~step_s;

  step_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fall_i  (fall),
    .hold_ni (hold_s),
    .dir_i   (dir_s),
    .full_i  (full_s),
    .pos_o   (pos),
    .accept_o(accept)
  );

  idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(accept),
    .idle_o (idle)
  );

  assign drv       = drive_of(pos);
  assign phase_a_o = drv.pa;
  assign phase_b_o = drv.pb;
  assign dis_a_o   = drv.dis_a;
  assign dis_b_o   = drv.dis_b;
  assign origin_no = (pos != '0);
  assign idle_no   = ~idle;
endmodule

// File: rtl/stepper_phase_xlat_chk.sv
module stepper_phase_xlat_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hold_s,
  input logic       full_s,
  input logic       accept,
  input logic [2:0] pos,
  input logic       phase_a_o,
  input logic       phase_b_o,
  input logic       dis_a_o,
  input logic       dis_b_o,
  input logic       origin_no,
  input logic       idle_no
);
  assert_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!accept && hold_s) |=> $stable(pos));

  assert_one_dis_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dis_a_o, dis_b_o}));

  assert_full_even_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && full_s && !pos[0]) |=> !pos[0]);

  assert_odd_realign_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && full_s && pos[0]) |=> !pos[0]);

  assert_hold_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_s |=> (pos == 3'd0));

  assert_origin_pattern_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !origin_no |-> ({phase_a_o, phase_b_o, dis_a_o, dis_b_o} == 4'b1100));

  assert_idle_release_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> idle_no);
endmodule

bind stepper_phase_xlat stepper_phase_xlat_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .hold_s   (hold_s),
  .full_s   (full_s),
  .accept   (accept),
  .pos      (pos),
  .phase_a_o(phase_a_o),
  .phase_b_o(phase_b_o),
  .dis_a_o  (dis_a_o),
  .dis_b_o  (dis_b_o),
  .origin_no(origin_no),
  .idle_no  (idle_no)
);

// File: tb/tb_stepper_phase_xlat.sv
module tb_stepper_phase_xlat;
  localparam int unsigned IDLE = 60;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic step_i = 1'b1, dir_i = 1'b1, full_step_i = 1'b0, hold_ni = 1'b1;
  logic phase_a_o, phase_b_o, dis_a_o, dis_b_o, origin_no, idle_no;

  int errors = 0, checks = 0;
  int model_pos = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  stepper_phase_xlat #(.IDLE_CYCLES(IDLE)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .step_i(step_i), .dir_i(dir_i),
    .full_step_i(full_step_i), .hold_ni(hold_ni),
    .phase_a_o(phase_a_o), .phase_b_o(phase_b_o), .dis_a_o(dis_a_o),
    .dis_b_o(dis_b_o), .origin_no(origin_no), .idle_no(idle_no)
  );

  function automatic logic [3:0] exp_drive(int p);
    case (p)
      0: return 4'b1100;
      1: return 4'b1101;
      2: return 4'b1000;
      3: return 4'b1010;
      4: return 4'b0000;
      5: return 4'b0001;
      6: return 4'b0100;
      default: return 4'b0110;
    endcase
  endfunction

  function automatic int next_pos(int p, bit d, bit f);
    int inc = (f && (p % 2 == 0)) ? 2 : 1;
    return d ? (p + inc) % 8 : (p + 8 - inc) % 8;
  endfunction

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
    @(negedge clk);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_out(string req);
    @(negedge clk);
    checks++;
    if ({phase_a_o, phase_b_o, dis_a_o, dis_b_o, origin_no} !==
        {exp_drive(model_pos), model_pos != 0}) begin
      errors++;
      $display("FAIL %s: got %b expected %b (pos %0d)", req,
               {phase_a_o, phase_b_o, dis_a_o, dis_b_o, origin_no},
               {exp_drive(model_pos), model_pos != 0}, model_pos);
    end
  endtask

  task automatic pulse(bit d, bit f, string req);
    dir_i = d; full_step_i = f;
    cyc(3);
    step_i = 1'b0;
    if (hold_ni) model_pos = next_pos(model_pos, d, f);
    cyc(4);
    chk_out(req);
    step_i = 1'b1;
    cyc(4);
    chk_out({req, " R1 rise ignored"});
  endtask

  initial begin
    void'($urandom(32'h5eed_7a11));
    cyc(3);
    chk_out("R9 reset pattern");
    chk_out("R10 origin at reset");
    rst_ni = 1'b1;
    cyc(2);

    // half-step forward full cycle
    for (int i = 0; i < 8; i++) pulse(1'b1, 1'b0, "R4 R5 half forward");
    chk("R4 repeat after 8", {4'b0, origin_no}, 5'b0);
    // half-step reverse
    for (int i = 0; i < 3; i++) pulse(1'b0, 1'b0, "R5 half reverse");
    // odd position (5), switch to full forward: realign to 6
    pulse(1'b1, 1'b1, "R6 odd realign forward");
    for (int i = 0; i < 4; i++) pulse(1'b1, 1'b1, "R3 full forward");
    chk("R3 no disable in full", {3'b0, dis_a_o, dis_b_o}, 5'b0);
    pulse(1'b0, 1'b0, "R4 half step off grid");
    pulse(1'b0, 1'b1, "R6 odd realign reverse");

    // R7: toggle dir/mode without an edge
    dir_i = ~dir_i; full_step_i = ~full_step_i;
    cyc(6);
    chk_out("R7 dir/mode change without edge");

    // R11 idle timing
    pulse(1'b1, 1'b0, "R1 step before idle");
    cyc(IDLE - 30);
    chk("R11 not yet idle", {4'b0, idle_no}, 5'b1);
    cyc(40);
    chk("R11 idle asserted", {4'b0, idle_no}, 5'b0);
    pulse(1'b1, 1'b0, "R11 step after idle");
    chk("R11 idle released", {4'b0, idle_no}, 5'b1);

    // R8 hold
    hold_ni = 1'b0;
    model_pos = 0;
    cyc(5);
    chk_out("R8 hold forces start");
    pulse(1'b1, 1'b0, "R8 step ignored in hold");
    pulse(1'b1, 1'b1, "R8 step ignored in hold full");
    hold_ni = 1'b1;
    cyc(4);
    pulse(1'b1, 1'b0, "R8 released resumes");

    // random mix
    for (int i = 0; i < 200; i++) begin
      pulse(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R2 random");
      if ($urandom_range(0, 15) == 0) begin
        dir_i = 1'($urandom_range(0, 1));
        full_step_i = 1'($urandom_range(0, 1));
        cyc(5);
        chk_out("R7 random input wiggle");
      end
    end

    // async reset mid-sequence
    pulse(1'b1, 1'b0, "R2 before reset");
    rst_ni = 1'b0;
    model_pos = 0;
    cyc(2);
    chk_out("R9 reset mid-run");
    rst_ni = 1'b1;
    cyc(3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule